// File: doc/BRIEF.md
# Single-Cycle Word-Parallel CRC Engine

This block keeps a running cyclic redundancy check over a byte stream and absorbs one complete data word per clock. The word is one byte or several byte lanes wide. Each lane is one message byte. Parameters set the register width, the generator polynomial, the starting value, the shift-register form, the bit reflection and the output complement. One netlist can therefore produce the common Ethernet CRC-32, the Castagnoli CRC-32C, or an unreflected variant.

The user holds `in_valid` high for each cycle that carries a word. The engine has no back-pressure path: it accepts a word on every clock where `in_valid` is high. `crc_value` is a registered result. It covers every word accepted up to the latest rising edge. A synchronous reset starts a new message.

Top module: `crc_fold_engine`

## Requirements
- R1: With the default parameters (width 32, polynomial 0x04C11DB7, start value all ones, Galois form, reflection on, complement on), the result for the ASCII bytes "123456789" is 0xCBF43926.
- R2: With polynomial 0x1EDC6F41 and all other settings at their defaults, the result for "123456789" is 0xE3069283.
- R3: After reset the internal register holds the start value. `crc_value` then shows that value after the output reflection and complement. With start all ones, reflection on and complement off, this is 0xFFFFFFFF.
- R4: In Galois form each message bit b does two things: it shifts the register left by one, and when the old top bit XOR b is 1 it XORs the polynomial in. In Fibonacci form the new bit 0 is b XOR the parity of the register masked by {1, POLY[W-1:1]}, and the rest shifts left. In both forms an all-zero word leaves an all-zero register unchanged.
- R5: With reflection on, each byte is fed from bit 0 upward and the output is bit-reversed. With reflection off, each byte is fed from bit 7 downward and the output is not reversed. The unreflected, uncomplemented setting gives 0x0376E6E7 for "123456789".
- R6: With complement on, the output is the bitwise inverse of the value that would otherwise appear. After reset with the defaults, it reads 0x00000000.
- R7: The data width is any multiple of 8. Widths of 8 and 64 bits each absorb a full word in one cycle.
- R8: Lane 0 (bits 7:0) is the earliest byte and the later lanes follow in ascending order. A 64-bit engine and an 8-bit engine fed the same byte sequence give the same result.
- R9: The register changes only on edges where `in_valid` is high. On other edges `crc_value` holds even when `in_data` changes.
- R10: Reset has priority over `in_valid`. A word presented during reset is discarded and the start value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Message word, lane 0 earliest |
| in_valid | input | 1 | Word strobe; word absorbed at this edge |
| crc_value | output | CRC_W | Running CRC after reflection and complement |

## Verification
A word presented with `in_valid` high at a rising edge appears in `crc_value` straight after that same edge, because only one register lies on the path. A reset edge likewise shows the start value right after the edge. The bench drives inputs on falling edges and queues the expected result of each word. Its monitor samples `in_valid` and `rst` at the rising edge and compares the output one nanosecond later. An idle edge expects the previously queued value to stay unchanged.

// File: rtl/crc_fold_pkg.sv
package crc_fold_pkg;

  typedef enum logic {
    FORM_FIBONACCI = 1'b0,
    FORM_GALOIS    = 1'b1
  } lfsr_form_e;

  // Position in the data word of the n-th message bit to be fed.
  function automatic int feed_index(input int n, input bit reflect);
    int lane;
    int pos;
    lane = n / 8;
    pos  = n % 8;
    return reflect ? n : (lane * 8 + 7 - pos);
  endfunction

endpackage

// File: rtl/crc_fold_net.sv
module crc_fold_net #(
  parameter int                     CRC_W   = 32,
  parameter int                     DATA_W  = 8,
  parameter logic [CRC_W-1:0]       POLY    = 32'h04C11DB7,
  parameter crc_fold_pkg::lfsr_form_e FORM  = crc_fold_pkg::FORM_GALOIS,
  parameter bit                     REFLECT = 1'b1
) (
  input  logic [CRC_W-1:0]  state_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  next_o
);
  localparam logic [CRC_W-1:0] FIB_MASK = {1'b1, POLY[CRC_W-1:1]};

  generate
    if (FORM == crc_fold_pkg::FORM_GALOIS) begin : g_galois
      logic [CRC_W-1:0] s;
      logic             fb;
      always_comb begin
        s  = state_i;
        fb = 1'b0;
        for (int n = 0; n < DATA_W; n++) begin
          fb = s[CRC_W-1] ^ data_i[crc_fold_pkg::feed_index(n, REFLECT)];
          s  = {s[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        next_o = s;
      end
    end else begin : g_fibonacci
      logic [CRC_W-1:0] s;
      logic             fb;
      always_comb begin
        s  = state_i;
        fb = 1'b0;
        for (int n = 0; n < DATA_W; n++) begin
          fb = data_i[crc_fold_pkg::feed_index(n, REFLECT)] ^ (^(s & FIB_MASK));
          s  = {s[CRC_W-2:0], fb};
        end
        next_o = s;
      end
    end
  endgenerate
endmodule

// File: rtl/crc_fold_reg.sv
module crc_fold_reg #(
  parameter int               CRC_W = 32,
  parameter logic [CRC_W-1:0] INIT  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CRC_W-1:0] next_i,
  output logic [CRC_W-1:0] state_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= INIT;
    end else if (load_i) begin
      state_o <= next_i;
    end
  end
endmodule

// File: rtl/crc_fold_shape.sv
module crc_fold_shape #(
  parameter int CRC_W   = 32,
  parameter bit REFLECT = 1'b1,
  parameter bit INVERT  = 1'b1
) (
  input  logic [CRC_W-1:0] state_i,
  output logic [CRC_W-1:0] value_o
);
  localparam logic [CRC_W-1:0] FLIP = INVERT ? '1 : '0;

  logic [CRC_W-1:0] ordered;

  generate
    if (REFLECT) begin : g_rev
      for (genvar i = 0; i < CRC_W; i++) begin : g_bit
        assign ordered[i] = state_i[CRC_W-1-i];
      end
    end else begin : g_direct
      assign ordered = state_i;
    end
  endgenerate

  assign value_o = ordered ^ FLIP;
endmodule

// File: rtl/crc_fold_engine.sv
module crc_fold_engine #(
  parameter int               CRC_W   = 32,
  parameter logic [CRC_W-1:0] POLY    = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] INIT    = '1,
  parameter bit               GALOIS  = 1'b1,
  parameter bit               REFLECT = 1'b1,
  parameter bit               INVERT  = 1'b1,
  parameter int               DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic [CRC_W-1:0]  crc_value
);
  localparam crc_fold_pkg::lfsr_form_e FORM =
    GALOIS ? crc_fold_pkg::FORM_GALOIS : crc_fold_pkg::FORM_FIBONACCI;

  logic [CRC_W-1:0] state_q;
  logic [CRC_W-1:0] state_nx;

  crc_fold_net #(
    .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .FORM(FORM), .REFLECT(REFLECT)
  ) u_net (
    .state_i(state_q), .data_i(in_data), .next_o(state_nx)
  );

  crc_fold_reg #(.CRC_W(CRC_W), .INIT(INIT)) u_reg (
    .clk(clk), .rst(rst), .load_i(in_valid), .next_i(state_nx), .state_o(state_q)
  );

  crc_fold_shape #(.CRC_W(CRC_W), .REFLECT(REFLECT), .INVERT(INVERT)) u_shape (
    .state_i(state_q), .value_o(crc_value)
  );
endmodule

// File: rtl/crc_fold_chk.sv
module crc_fold_chk #(
  parameter int               CRC_W  = 32,
  parameter int               DATA_W = 8,
  parameter logic [CRC_W-1:0] INIT   = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic [CRC_W-1:0]  state_q,
  input logic [CRC_W-1:0]  crc_value
);
  logic rst_seen;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      // R3 and R10: an edge with reset loads the start value whatever in_valid was
      a_r3_reset_loads_start: assert (state_q == INIT);
    end
  end

  a_r9_output_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(crc_value));

  a_r9_state_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(state_q));

  a_r4_zero_stays_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && state_q == '0 && in_data == '0) |=> state_q == '0);
endmodule

bind crc_fold_engine crc_fold_chk #(
  .CRC_W(CRC_W), .DATA_W(DATA_W), .INIT(INIT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .state_q(state_q), .crc_value(crc_value)
);

// File: tb/crc_fold_engine_tb_top.sv
`timescale 1ns/1ps
module crc_fold_engine_tb_top;
  localparam int N = 6;

  function automatic int dw(input int i);
    case (i)
      1, 3: return 64;
      5: return 16;
      default: return 8;
    endcase
  endfunction
  function automatic logic [31:0] cfg_poly(input int i);
    return (i == 2 || i == 3) ? 32'h1EDC6F41 : 32'h04C11DB7;
  endfunction
  function automatic bit cfg_galois(input int i);  return i != 5; endfunction
  function automatic bit cfg_reflect(input int i); return i != 4; endfunction
  function automatic bit cfg_invert(input int i);  return i < 4;  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] din [N];
  logic        vld [N];
  logic [31:0] cout [N];
  logic [31:0] ms [N];
  logic [31:0] exp_q [N][$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_dut
    localparam int DW = dw(g);
    crc_fold_engine #(
      .CRC_W(32), .POLY(cfg_poly(g)), .INIT('1), .GALOIS(cfg_galois(g)),
      .REFLECT(cfg_reflect(g)), .INVERT(cfg_invert(g)), .DATA_W(DW)
    ) dut_i (
      .clk(clk), .rst(rst), .in_data(din[g][DW-1:0]), .in_valid(vld[g]),
      .crc_value(cout[g])
    );
  end

  // Reference model taken from R4/R5/R6.
  function automatic logic [31:0] mdl_bit(input int i, input logic [31:0] s, input logic b);
    logic fb;
    if (cfg_galois(i)) begin
      fb = s[31] ^ b;
      return {s[30:0], 1'b0} ^ (fb ? cfg_poly(i) : 32'h0);
    end
    fb = b ^ (^(s & {1'b1, cfg_poly(i)[31:1]}));
    return {s[30:0], fb};
  endfunction
  function automatic logic [31:0] mdl_byte(input int i, input logic [31:0] s, input logic [7:0] b);
    logic [31:0] r;
    r = s;
    for (int k = 0; k < 8; k++) r = mdl_bit(i, r, cfg_reflect(i) ? b[k] : b[7-k]);
    return r;
  endfunction
  function automatic logic [31:0] out_of(input int i, input logic [31:0] s);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = cfg_reflect(i) ? s[31-k] : s[k];
    return cfg_invert(i) ? ~r : r;
  endfunction
  function automatic string vtag(input int i);
    case (i)
      0: return "R1";
      1: return "R7";
      2: return "R2";
      3: return "R8";
      4: return "R5";
      default: return "R4";
    endcase
  endfunction
  function automatic logic [7:0] mk(input int mode, input int k);
    logic [71:0] txt;
    txt = "123456789";
    case (mode)
      0: return k[7:0];
      1: return txt[71-8*k -: 8];
      default: return 8'((k + 1) * 8'h11);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Scoreboard monitors, one per engine
  for (genvar g = 0; g < N; g++) begin : g_mon
    initial begin
      logic [31:0] cur;
      string       tag;
      cur = 32'h0;
      forever begin
        @(posedge clk);
        if (rst) begin
          cur = out_of(g, 32'hFFFFFFFF);
          tag = "R10";
        end else if (vld[g]) begin
          tag = vtag(g);
          if (exp_q[g].size() != 0) cur = exp_q[g].pop_front();
          else check(1'b0, tag, cout[g], cur);
        end else begin
          tag = "R9";
        end
        #1;
        check(cout[g] === cur, tag, cout[g], cur);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < N; i++) ms[i] = 32'hFFFFFFFF;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic feed(input int i, input int nbytes, input int mode, input bit gaps);
    int lanes;
    lanes = dw(i) / 8;
    for (int w = 0; w < nbytes / lanes; w++) begin
      logic [63:0] word;
      word = 64'h0;
      for (int l = 0; l < lanes; l++) begin
        logic [7:0] b;
        b = mk(mode, w * lanes + l);
        word[l*8 +: 8] = b;
        ms[i] = mdl_byte(i, ms[i], b);
      end
      @(negedge clk);
      din[i] = word;
      vld[i] = 1'b1;
      exp_q[i].push_back(out_of(i, ms[i]));
      if (gaps && (w % 3 == 2)) begin
        @(negedge clk);
        vld[i] = 1'b0;
        din[i] = ~word;
      end
    end
    @(negedge clk);
    vld[i] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      din[i] = 64'h0;
      vld[i] = 1'b0;
      ms[i]  = 32'hFFFFFFFF;
    end
    do_reset();
    check(cout[0] === 32'h00000000, "R6", cout[0], 32'h00000000);
    check(cout[4] === 32'hFFFFFFFF, "R3", cout[4], 32'hFFFFFFFF);

    feed(0, 9, 1, 1'b0);
    check(cout[0] === 32'hCBF43926, "R1", cout[0], 32'hCBF43926);
    feed(2, 9, 1, 1'b1);
    check(cout[2] === 32'hE3069283, "R2", cout[2], 32'hE3069283);
    feed(4, 9, 1, 1'b0);
    check(cout[4] === 32'h0376E6E7, "R5", cout[4], 32'h0376E6E7);

    do_reset();
    for (int i = 0; i < 4; i++) feed(i, 8, 2, 1'b0);
    check(cout[1] === cout[0], "R8", cout[1], cout[0]);
    check(cout[3] === cout[2], "R8", cout[3], cout[2]);

    do_reset();
    for (int i = 0; i < N; i++) feed(i, 1024, 0, 1'b1);
    check(cout[1] === cout[0], "R8", cout[1], cout[0]);
    check(cout[3] === cout[2], "R7", cout[3], cout[2]);

    // R10: word presented during reset is discarded
    feed(0, 4, 2, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    vld[0] = 1'b1;
    din[0] = 64'h5A;
    for (int i = 0; i < N; i++) ms[i] = 32'hFFFFFFFF;
    @(negedge clk);
    rst = 1'b0;
    vld[0] = 1'b0;
    check(cout[0] === 32'h00000000, "R10", cout[0], 32'h00000000);
    @(negedge clk);
    check(cout[0] === 32'h00000000, "R9", cout[0], 32'h00000000);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule